// File: doc/BRIEF.md
# Four-Line Serial Byte Receiver with Shared Quarter-Bit Timebase

This block receives bytes on four asynchronous NRZ serial lines at 31250 bit/s, from a 20 MHz system clock. One divider produces a strobe every quarter bit, which is 160 clocks, and all four lines share it. Each line has its own synchroniser, falling-edge detector and small countdown of ticks. That countdown places the line's samples near the middle of each bit, whatever phase the incoming frame has against the shared strobe. No per-line baud generator is needed, and no 16x oversampling.

A frame is one low start bit, eight data bits sent least significant bit first, and one high stop bit, with no parity. After a start edge, a line's edge detector is ignored until the frame ends. The first sample falls two ticks after the edge and checks again that the line is still low. After that the line is sampled every four ticks. A byte with a good stop bit is presented on that line's data lane with a one-cycle valid strobe. A byte whose stop sample reads low is dropped, and a one-cycle framing-error strobe is raised in its place.

Top module: `multi_serial_rx`

## Requirements
- R1: After reset, all valid and framing-error strobes are low and every data lane reads zero.
- R2: A frame with a high stop bit produces, on its line, exactly one single-cycle valid strobe. The byte appears on that line's lane (lane c is bits 8c+7..8c), with the first data bit received in bit 0.
- R3: The four lines work independently. Frames that overlap in time, at unrelated phases, are each received correctly on their own lane.
- R4: A low pulse that is gone by the first mid-bit sample, two ticks after the edge, produces no strobe. The line then receives the next frame normally.
- R5: A frame whose stop sample is low produces one single-cycle framing-error strobe and no valid strobe. That line's data lane keeps its last valid byte.
- R6: After a framing error, a line held low does not start a new frame. A new frame starts only at the next high-to-low transition.
- R7: On any line, valid and framing-error strobes are never high together, and neither stays high for two consecutive cycles.
- R8: Frames sent back to back, with the next start bit right after a stop bit, are all received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_i | input | NUM_CH | Serial lines, idle high, one bit per line |
| data_o | output | NUM_CH*DATA_BITS | Received bytes, lane c holds line c |
| valid_o | output | NUM_CH | One-cycle strobe per line: new byte on its lane |
| ferr_o | output | NUM_CH | One-cycle strobe per line: stop bit read low, byte dropped |

## Verification
A wrong phase count or a bad shared tick moves the sample point off the middle of the bit. This shows up at the ports within one frame: the byte is shifted by one bit, or the valid and framing-error strobes swap. A state that fails to return to idle, or an edge detector that stays armed during a frame, shows within the next frame on that line as a missing or extra strobe. Lines run at random phase offsets, so that a wrong count in one line's tick bookkeeping corrupts that lane alone.

// File: rtl/msrx_pkg.sv
package msrx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

endpackage

// File: rtl/msrx_tick_gen.sv
module msrx_tick_gen #(
  parameter int DIV = 160
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          wrap;

  assign wrap   = (cnt_q == CW'(DIV - 1));
  assign tick_o = wrap;

  always_comb begin
    cnt_d = wrap ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/msrx_sync2.sv
module msrx_sync2 #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      sync_q <= '1;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/msrx_channel.sv
module msrx_channel
  import msrx_pkg::*;
#(
  parameter int DATA_BITS     = 8,
  parameter int TICKS_PER_BIT = 4,
  parameter int START_TICKS   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_i,
  input  logic                 line_i,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 valid_o,
  output logic                 ferr_o
);
  localparam int PMAX = (TICKS_PER_BIT > START_TICKS) ? TICKS_PER_BIT : START_TICKS;
  localparam int PW   = $clog2(PMAX + 1);
  localparam int BW   = $clog2(DATA_BITS);

  rx_state_e            state_q, state_d;
  logic                 line_q;
  logic [PW-1:0]        phase_q, phase_d;
  logic [BW-1:0]        bit_q, bit_d;
  logic [DATA_BITS-1:0] shift_q, shift_d;
  logic [DATA_BITS-1:0] data_q, data_d;
  logic                 valid_q, valid_d;
  logic                 ferr_q, ferr_d;
  logic                 sample;

  assign sample = tick_i && (phase_q == PW'(1));

  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    bit_d   = bit_q;
    shift_d = shift_q;
    data_d  = data_q;
    valid_d = 1'b0;
    ferr_d  = 1'b0;
    if (state_q == RX_IDLE) begin
      if (line_q && !line_i) begin
        state_d = RX_START;
        phase_d = PW'(START_TICKS);
      end
    end else begin
      if (tick_i) phase_d = sample ? PW'(TICKS_PER_BIT) : phase_q - PW'(1);
      if (sample) begin
        unique case (state_q)
          RX_START: begin
            if (line_i) state_d = RX_IDLE;
            else begin
              state_d = RX_DATA;
              bit_d   = '0;
            end
          end
          RX_DATA: begin
            shift_d = {line_i, shift_q[DATA_BITS-1:1]};
            bit_d   = bit_q + BW'(1);
            if (bit_q == BW'(DATA_BITS - 1)) state_d = RX_STOP;
          end
          RX_STOP: begin
            state_d = RX_IDLE;
            if (line_i) begin
              valid_d = 1'b1;
              data_d  = shift_q;
            end else begin
              ferr_d  = 1'b1;
            end
          end
          default: state_d = RX_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      line_q  <= 1'b1;
      phase_q <= '0;
      bit_q   <= '0;
      shift_q <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      line_q  <= line_i;
      phase_q <= phase_d;
      bit_q   <= bit_d;
      shift_q <= shift_d;
      data_q  <= data_d;
      valid_q <= valid_d;
      ferr_q  <= ferr_d;
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;
  assign ferr_o  = ferr_q;
endmodule

// File: rtl/multi_serial_rx.sv
module multi_serial_rx #(
  parameter int NUM_CH        = 4,
  parameter int DATA_BITS     = 8,
  parameter int CLK_HZ        = 20_000_000,
  parameter int BAUD          = 31_250,
  parameter int TICKS_PER_BIT = 4,
  parameter int START_TICKS   = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_CH-1:0]             rx_i,
  output logic [NUM_CH*DATA_BITS-1:0]   data_o,
  output logic [NUM_CH-1:0]             valid_o,
  output logic [NUM_CH-1:0]             ferr_o
);
  localparam int TICK_DIV = CLK_HZ / (BAUD * TICKS_PER_BIT);

  logic              rst_meta_q, rst_sync_n;
  logic              tick;
  logic [NUM_CH-1:0] line_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  msrx_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .tick_o (tick)
  );

  msrx_sync2 #(.W(NUM_CH)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_i   (rx_i),
    .q_o   (line_sync)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    msrx_channel #(
      .DATA_BITS     (DATA_BITS),
      .TICKS_PER_BIT (TICKS_PER_BIT),
      .START_TICKS   (START_TICKS)
    ) u_ch (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .tick_i  (tick),
      .line_i  (line_sync[c]),
      .data_o  (data_o[c*DATA_BITS +: DATA_BITS]),
      .valid_o (valid_o[c]),
      .ferr_o  (ferr_o[c])
    );
  end
endmodule

// File: rtl/msrx_chk.sv
module msrx_chk #(
  parameter int NUM_CH    = 4,
  parameter int DATA_BITS = 8,
  parameter int TICK_DIV  = 160,
  parameter int TPB       = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [NUM_CH*DATA_BITS-1:0] data_o,
  input logic [NUM_CH-1:0]           valid_o,
  input logic [NUM_CH-1:0]           ferr_o
);
  localparam int MIN_GAP = DATA_BITS * TPB * TICK_DIV - 1;
  localparam int GW      = $clog2(MIN_GAP + 1);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    logic [GW-1:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      gap_q <= GW'(MIN_GAP);
      else if (valid_o[c] || ferr_o[c]) gap_q <= '0;
      else if (gap_q != GW'(MIN_GAP))   gap_q <= gap_q + GW'(1);
    end

    // R7
    excl_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(valid_o[c] && ferr_o[c]));

    // R7
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o[c] || ferr_o[c]) |=> !(valid_o[c] || ferr_o[c]));

    // R5
    lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(data_o[c*DATA_BITS +: DATA_BITS]) |-> valid_o[c]);

    // R6
    frame_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o[c] || ferr_o[c]) |-> (gap_q == GW'(MIN_GAP)));
  end
endmodule

bind multi_serial_rx msrx_chk #(
  .NUM_CH    (NUM_CH),
  .DATA_BITS (DATA_BITS),
  .TICK_DIV  (CLK_HZ / (BAUD * TICKS_PER_BIT)),
  .TPB       (TICKS_PER_BIT)
) u_msrx_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .data_o  (data_o),
  .valid_o (valid_o),
  .ferr_o  (ferr_o)
);

// File: tb/test_multi_serial_rx.sv
module test_multi_serial_rx;
  localparam int NCH  = 4;
  localparam int DIV  = 4;
  localparam int BITC = DIV * 4;

  logic             clk;
  logic             rst_n;
  logic [NCH-1:0]   rx;
  logic [NCH*8-1:0] data_o;
  logic [NCH-1:0]   valid_o;
  logic [NCH-1:0]   ferr_o;

  multi_serial_rx #(.NUM_CH(NCH), .CLK_HZ(500_000)) i_multi_serial_rx (
    .clk(clk), .rst_n(rst_n), .rx_i(rx),
    .data_o(data_o), .valid_o(valid_o), .ferr_o(ferr_o)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_d [NCH][64];
  bit         exp_e [NCH][64];
  int         wr [NCH];
  int         rd [NCH];
  int         nev [NCH];
  logic [7:0] last_good [NCH];
  logic [NCH-1:0] prev_strobe;
  bit monitor_on = 0;

  initial clk = 0;
  always #4 clk = ~clk;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit good_stop(int r);
    return r != 0;
  endfunction

  task automatic drive_bit(int c, bit v);
    rx[c] = v;
    repeat (BITC) @(negedge clk);
  endtask

  task automatic send(int c, logic [7:0] b, bit stop_ok);
    exp_d[c][wr[c]] = b;
    exp_e[c][wr[c]] = !stop_ok;
    wr[c]++;
    drive_bit(c, 1'b0);
    for (int i = 0; i < 8; i++) drive_bit(c, b[i]);
    drive_bit(c, stop_ok);
    rx[c] = 1'b1;
  endtask

  always @(negedge clk) begin
    if (monitor_on) begin
      for (int c = 0; c < NCH; c++) begin
        if (valid_o[c] && ferr_o[c]) check(0, "R7 both strobes", 1, 0);
        if (prev_strobe[c] && (valid_o[c] || ferr_o[c])) check(0, "R7 pulse width", 2, 1);
        if (valid_o[c] || ferr_o[c]) begin
          nev[c]++;
          if (rd[c] >= wr[c]) check(0, "R4/R6 unexpected strobe", c, -1);
          else if (valid_o[c]) begin
            check(exp_e[c][rd[c]] == 0, "R5 valid on bad stop", 1, 0);
            check(data_o[c*8 +: 8] == exp_d[c][rd[c]], "R2/R3 byte", int'(data_o[c*8 +: 8]), int'(exp_d[c][rd[c]]));
            last_good[c] = exp_d[c][rd[c]];
            rd[c]++;
          end else begin
            check(exp_e[c][rd[c]] == 1, "R5 ferr on good stop", 1, 0);
            check(data_o[c*8 +: 8] == last_good[c], "R5 lane held", int'(data_o[c*8 +: 8]), int'(last_good[c]));
            rd[c]++;
          end
        end
        prev_strobe[c] = valid_o[c] || ferr_o[c];
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rx = '1;
    rst_n = 0;
    prev_strobe = '0;
    for (int c = 0; c < NCH; c++) begin
      wr[c] = 0; rd[c] = 0; nev[c] = 0; last_good[c] = 8'h00;
    end
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(valid_o == '0, "R1 valid", int'(valid_o), 0);
    check(ferr_o == '0, "R1 ferr", int'(ferr_o), 0);
    check(data_o == '0, "R1 data", int'(data_o), 0);
    monitor_on = 1;

    // R2: directed patterns on line 0, bit order
    send(0, 8'h01, 1);
    send(0, 8'h80, 1);
    repeat (BITC) @(negedge clk);
    send(0, 8'h55, 1);

    // R4: short glitch on line 1, then a normal frame
    rx[1] = 0; repeat (2) @(negedge clk); rx[1] = 1;
    repeat (3 * BITC) @(negedge clk);
    check(nev[1] == 0, "R4 glitch strobe", nev[1], 0);
    send(1, 8'hA7, 1);
    repeat (2 * BITC) @(negedge clk);
    check(nev[1] == 1, "R4 frame after glitch", nev[1], 1);

    // R5 then R6: bad stop, line held low, then released
    send(2, 8'h3C, 0);
    rx[2] = 0;
    repeat (12 * BITC) @(negedge clk);
    check(nev[2] == 1, "R6 held low no restart", nev[2], 1);
    rx[2] = 1;
    repeat (2 * BITC) @(negedge clk);
    send(2, 8'hC3, 1);

    // R8: back to back on line 3
    send(3, 8'hFF, 1);
    send(3, 8'h00, 1);
    send(3, 8'h96, 1);
    repeat (2 * BITC) @(negedge clk);
    check(nev[3] == 3, "R8 back to back count", nev[3], 3);

    // R3: overlapping random frames at random phases
    for (int round = 0; round < 8; round++) begin
      for (int c = 0; c < NCH; c++) begin
        automatic int cc = c;
        automatic int lead = $urandom_range(0, BITC - 1);
        automatic logic [7:0] b = 8'($urandom());
        automatic bit ok = good_stop($urandom_range(0, 5));
        fork
          begin
            repeat (lead) @(negedge clk);
            send(cc, b, ok);
            if (!ok) drive_bit(cc, 1'b1);
          end
        join_none
      end
      wait fork;
      repeat (BITC) @(negedge clk);
    end

    repeat (3 * BITC) @(negedge clk);
    for (int c = 0; c < NCH; c++)
      check(rd[c] == wr[c], "R3 frames received", rd[c], wr[c]);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule